// File: doc/BRIEF.md
# Two-Virtual-Channel Link Multiplexer

This block sits on the sending side of a point-to-point link. It lets two virtual channels share one 8-bit data path. Each virtual channel feeds flits in through its own valid/ready stream into a private output queue. The link itself has the shared data lines plus one request wire and one acknowledge wire for each channel. The acknowledge wires are driven by the far end, against the direction of the data.

Only one channel holds the data lines at a time. The owning channel raises its request with its head flit and keeps both steady until its acknowledge comes back. The flit then leaves its queue, and the link is offered again to the queues that hold data. The channels therefore take turns one flit at a time, so a long packet on one channel does not shut the other out. An arbitration parameter selects the turn-taking rule: round-robin, or a fixed preference for channel 0.

Top module: `vc_link_mux`

## Requirements
- R1: While reset is held and right after it ends, both request wires are 0, the data lines read 0, and both input ready signals are 1.
- R2: At most one of the two request wires is 1 in any cycle.
- R3: Once a channel raises its request, its request stays 1 and the data lines stay unchanged in every following cycle until that channel's acknowledge is sampled high.
- R4: If a channel's acknowledge is high at a clock edge while its request is high, the request wire is 0 after that edge. That flit is removed from its queue, and no request of either channel is high in that following cycle.
- R5: With round-robin arbitration (ARB = ARB_ROUND), if both queues hold data when the link is free, the grant goes to the channel that was not served last. The first grant after reset goes to channel 0.
- R6: Each queue stores DEPTH flits, counting the one being presented on the link. A channel's ready is 0 exactly while its queue is full, and the other channel's ready does not depend on it.
- R7: A flit accepted at clock edge k into an empty queue, while the link is idle, has its request wire (bit 0 for channel 0, bit 1 for channel 1) high and its value on the data lines after edge k+1.
- R8: An acknowledge on a channel whose request is 0 has no effect. The current owner keeps its request and data, and no flit leaves either queue.
- R9: Within each channel, flits appear on the link in the order they were accepted. Every accepted flit is acknowledged exactly once, with no flit lost or repeated.
- R10: With fixed arbitration (ARB = ARB_FIXED), channel 0 is granted whenever both queues hold data while the link is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Per-channel flit valid, bit i for channel i |
| in_data | input | 2*W | Per-channel flit, channel i on bits [i*W +: W] |
| in_ready | output | 2 | Per-channel queue not full |
| link_data | output | W | Shared link data lines |
| link_req | output | 2 | Per-channel request, bit i for channel i |
| link_ack | input | 2 | Per-channel acknowledge from the receiver |

## Verification
The main instance is built with a queue depth of 4 and round-robin arbitration. At that depth a short burst with acknowledges withheld fills a queue, and the test can show the other channel's ready staying high. A second instance uses fixed arbitration and depth 4, so one simultaneous load of three flits per channel shows the whole preference order. Acknowledge delays are drawn at random per channel, from zero up to several cycles. Both the back-to-back handover and long hold periods occur, while the flit order of each channel is tracked.

// File: rtl/vcmux_pkg.sv
package vcmux_pkg;
  localparam int unsigned NUM_VC = 2;

  typedef enum logic {
    ARB_ROUND = 1'b0,
    ARB_FIXED = 1'b1
  } arb_e;
endpackage

// File: rtl/vcmux_queue.sv
module vcmux_queue #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         ready,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign ready    = (count != CW'(DEPTH));
  assign nonempty = (count != '0);
  assign do_push  = push && ready;
  assign do_pop   = pop && nonempty;
  assign head     = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/vcmux_arb.sv
module vcmux_arb
  import vcmux_pkg::*;
#(
  parameter arb_e ARB = ARB_ROUND
) (
  input  logic [NUM_VC-1:0] elig,
  input  logic              last_vc,
  output logic [NUM_VC-1:0] gnt
);
  generate
    if (ARB == ARB_ROUND) begin : g_round
      always_comb begin
        if (elig == 2'b11) gnt = last_vc ? 2'b01 : 2'b10;
        else               gnt = elig;
      end
    end else begin : g_fixed
      always_comb begin
        gnt = elig[0] ? 2'b01 : {elig[1], 1'b0};
      end
    end
  endgenerate
endmodule

// File: rtl/vc_link_mux.sv
module vc_link_mux
  import vcmux_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  parameter arb_e        ARB   = ARB_ROUND
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_VC-1:0]     in_valid,
  input  logic [NUM_VC*W-1:0]   in_data,
  output logic [NUM_VC-1:0]     in_ready,
  output logic [W-1:0]          link_data,
  output logic [NUM_VC-1:0]     link_req,
  input  logic [NUM_VC-1:0]     link_ack
);
  logic [W-1:0]      head [NUM_VC];
  logic [NUM_VC-1:0] nonempty, pop, elig, gnt;
  logic              last_vc, busy;

  generate
    for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
      vcmux_queue #(.W(W), .DEPTH(DEPTH)) u_q (
        .clk      (clk),
        .rst      (rst),
        .push     (in_valid[i]),
        .din      (in_data[i*W +: W]),
        .ready    (in_ready[i]),
        .pop      (pop[i]),
        .head     (head[i]),
        .nonempty (nonempty[i])
      );
    end
  endgenerate

  assign busy = |link_req;
  assign pop  = link_req & link_ack;   // acknowledge counts only for the owner
  assign elig = busy ? '0 : nonempty;

  vcmux_arb #(.ARB(ARB)) u_arb (
    .elig    (elig),
    .last_vc (last_vc),
    .gnt     (gnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      link_req  <= '0;
      link_data <= '0;
      last_vc   <= 1'b1;               // channel 0 first after reset
    end else if (busy) begin
      if (|pop) begin
        link_req <= '0;
        last_vc  <= pop[1];
      end
    end else if (|gnt) begin
      link_req  <= gnt;
      link_data <= head[gnt[1]];
    end
  end
endmodule

// File: rtl/vcmux_chk.sv
module vcmux_chk
  import vcmux_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_VC-1:0] in_valid,
  input logic [NUM_VC-1:0] in_ready,
  input logic [W-1:0]      link_data,
  input logic [NUM_VC-1:0] link_req,
  input logic [NUM_VC-1:0] link_ack
);
  localparam int unsigned CW = $clog2(DEPTH + 1) + 1;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0(link_req)); // R2

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ((link_req & link_ack) != '0) |=> (link_req == '0)); // R4

  generate
    for (genvar i = 0; i < NUM_VC; i++) begin : g_chk
      logic [CW-1:0] occ;
      always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + CW'(in_valid[i] & in_ready[i])
                            - CW'(link_req[i] & link_ack[i]);
      end

      AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (link_req[i] && !link_ack[i]) |=> (link_req[i] && $stable(link_data))); // R3

      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH)); // R6
    end
  endgenerate
endmodule

bind vc_link_mux vcmux_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .link_data (link_data),
  .link_req  (link_req),
  .link_ack  (link_ack)
);

// File: tb/vc_link_mux_tb_top.sv
`timescale 1ns/1ps
module vc_link_mux_tb_top;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic v0 = 1'b0, v1 = 1'b0;
  logic [W-1:0] d0 = '0, d1 = '0;
  logic a0 = 1'b0, a1 = 1'b0;
  logic [1:0] man_ack = 2'b00;
  wire  [1:0] in_valid = {v1, v0};
  wire  [2*W-1:0] in_data = {d1, d0};
  wire  [1:0] link_ack = {a1, a0} | man_ack;
  logic [1:0] in_ready, link_req;
  logic [W-1:0] link_data;

  vc_link_mux #(.W(W), .DEPTH(D), .ARB(vcmux_pkg::ARB_ROUND)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .link_data(link_data), .link_req(link_req),
    .link_ack(link_ack)
  );

  logic [1:0] fp_valid = 2'b00;
  logic [2*W-1:0] fp_data = '0;
  logic fp_auto = 1'b0;
  logic [1:0] fp_ready, fp_req;
  logic [W-1:0] fp_ldata;
  wire  [1:0] fp_ack = fp_req & {2{fp_auto}};

  vc_link_mux #(.W(W), .DEPTH(D), .ARB(vcmux_pkg::ARB_FIXED)) dut_fp_i (
    .clk(clk), .rst(rst), .in_valid(fp_valid), .in_data(fp_data),
    .in_ready(fp_ready), .link_data(fp_ldata), .link_req(fp_req),
    .link_ack(fp_ack)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q0[$];
  logic [W-1:0] exp_q1[$];
  int order_q[$];
  int sent0 = 0, sent1 = 0, rcvd0 = 0, rcvd1 = 0;
  logic resp_en = 1'b0;
  int maxd = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // compare a flit leaving the link with the per-channel expectation (R9)
  task automatic take(int vc, logic [W-1:0] d);
    logic [W-1:0] e;
    order_q.push_back(vc);
    if (vc == 0) begin
      rcvd0++;
      if (exp_q0.size() == 0) chk(1'b0, "R9 extra flit vc0", d, -1);
      else begin e = exp_q0.pop_front(); chk(d == e, "R9 order vc0", d, e); end
    end else begin
      rcvd1++;
      if (exp_q1.size() == 0) chk(1'b0, "R9 extra flit vc1", d, -1);
      else begin e = exp_q1.pop_front(); chk(d == e, "R9 order vc1", d, e); end
    end
  endtask

  // called at a falling edge, returns at the falling edge after acceptance
  task automatic send(int vc, logic [W-1:0] d);
    bit r;
    if (vc == 0) begin v0 = 1'b1; d0 = d; end
    else         begin v1 = 1'b1; d1 = d; end
    do begin
      r = in_ready[vc];
      @(negedge clk);
    end while (!r);
    if (vc == 0) begin v0 = 1'b0; exp_q0.push_back(d); sent0++; end
    else         begin v1 = 1'b0; exp_q1.push_back(d); sent1++; end
  endtask

  task automatic resp(int vc);
    int n;
    logic [W-1:0] hd;
    forever begin
      @(negedge clk);
      if (resp_en && link_req[vc]) begin
        n  = $urandom_range(maxd, 0);
        hd = link_data;
        repeat (n) begin
          @(negedge clk);
          chk(link_req[vc] && link_data == hd, "R3 hold until ack", link_data, hd);
        end
        take(vc, link_data);
        if (vc == 0) a0 = 1'b1; else a1 = 1'b1;
        @(negedge clk);
        if (vc == 0) a0 = 1'b0; else a1 = 1'b0;
        chk(link_req == 2'b00, "R4 request released", link_req, 0);
      end
    end
  endtask

  initial resp(0);
  initial resp(1);

  task automatic wait_idle();
    while (exp_q0.size() != 0 || exp_q1.size() != 0 || link_req != 2'b00)
      @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(link_req == 2'b00, "R1 reset req", link_req, 0);
    chk(link_data == '0, "R1 reset data", link_data, 0);
    chk(in_ready == 2'b11, "R1 reset ready", in_ready, 3);
  endtask

  task automatic t_latency();
    resp_en = 1'b0;
    send(1, 8'h5A);
    chk(link_req == 2'b00, "R7 not before edge k+1", link_req, 0);
    @(negedge clk);
    chk(link_req == 2'b10, "R7 request after edge k+1", link_req, 2);
    chk(link_data == 8'h5A, "R7 data after edge k+1", link_data, 8'h5A);
    take(1, link_data);
    man_ack = 2'b10;
    @(negedge clk);
    man_ack = 2'b00;
    chk(link_req == 2'b00, "R4 drop after ack", link_req, 0);
  endtask

  task automatic t_wrong_ack();
    send(0, 8'h33);
    @(negedge clk);
    chk(link_req == 2'b01, "R8 owner raised", link_req, 1);
    man_ack = 2'b10;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(link_req == 2'b01 && link_data == 8'h33, "R8 foreign ack ignored", link_data, 8'h33);
    end
    take(0, link_data);
    man_ack = 2'b01;
    @(negedge clk);
    man_ack = 2'b00;
    chk(link_req == 2'b00, "R4 drop after owner ack", link_req, 0);
    chk(in_ready == 2'b11, "R8 queues unchanged", in_ready, 3);
  endtask

  task automatic t_full();
    resp_en = 1'b0;
    for (int i = 0; i < D; i++) send(0, 8'h10 + 8'(i));
    chk(in_ready[0] == 1'b0, "R6 vc0 full", in_ready[0], 0);
    chk(in_ready[1] == 1'b1, "R6 vc1 still ready", in_ready[1], 1);
    send(1, 8'hA1);
    chk(link_req == 2'b01, "R2 single owner", link_req, 1);
    maxd = 2;
    resp_en = 1'b1;
    wait_idle();
    resp_en = 1'b0;
    chk(in_ready == 2'b11, "R6 ready after drain", in_ready, 3);
  endtask

  task automatic t_round();
    resp_en = 1'b0;
    fork
      for (int i = 0; i < 3; i++) send(0, 8'h60 + 8'(i));
      for (int i = 0; i < 3; i++) send(1, 8'h70 + 8'(i));
    join
    order_q.delete();
    maxd = 0;
    resp_en = 1'b1;
    wait_idle();
    resp_en = 1'b0;
    chk(order_q.size() == 6, "R5 served count", order_q.size(), 6);
    for (int i = 1; i < order_q.size(); i++)
      chk(order_q[i] != order_q[i-1], "R5 alternation", order_q[i], 1 - order_q[i-1]);
  endtask

  task automatic t_stress();
    maxd = 4;
    resp_en = 1'b1;
    fork
      for (int i = 0; i < 30; i++) begin
        send(0, 8'(i * 7 + 1));
        repeat ($urandom_range(2, 0)) @(negedge clk);
      end
      for (int i = 0; i < 30; i++) begin
        send(1, 8'(i * 5 + 128));
        repeat ($urandom_range(3, 0)) @(negedge clk);
      end
    join
    wait_idle();
    resp_en = 1'b0;
    chk(rcvd0 == sent0, "R9 vc0 count", rcvd0, sent0);
    chk(rcvd1 == sent1, "R9 vc1 count", rcvd1, sent1);
  endtask

  task automatic t_prio();
    int got[$];
    logic [W-1:0] gd[$];
    for (int i = 0; i < 3; i++) begin
      fp_valid = 2'b11;
      fp_data  = {8'h50 + 8'(i), 8'h40 + 8'(i)};
      @(negedge clk);
    end
    fp_valid = 2'b00;
    fp_auto  = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (fp_req != 2'b00) begin got.push_back(int'(fp_req[1])); gd.push_back(fp_ldata); end
      @(negedge clk);
    end
    fp_auto = 1'b0;
    chk(got.size() == 6, "R10 flit count", got.size(), 6);
    for (int i = 0; i < got.size() && i < 6; i++) begin
      chk(got[i] == (i < 3 ? 0 : 1), "R10 channel 0 preferred", got[i], (i < 3 ? 0 : 1));
      chk(gd[i] == (i < 3 ? 8'h40 + 8'(i) : 8'h50 + 8'(i - 3)), "R10 data", gd[i],
          (i < 3 ? 8'h40 + i : 8'h50 + i - 3));
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_wrong_ack();
    t_full();
    t_round();
    t_stress();
    t_prio();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule